// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor-side requester and a word-wide backing memory and keeps a direct-mapped cache of fixed-size blocks. Each word address is cut into three fields. The middle field picks the single slot that may hold the block. The top field is compared with the tag stored in that slot. The low field picks a word inside the block. Because only one slot can ever match, no search over several slots is needed.

A hit finishes without any memory traffic. A write hit changes the cached word and marks the slot dirty. On a miss, the slot's old contents are handled first. If the slot holds a different block that is dirty, that block is copied back to memory one word at a time. The wanted block is then fetched one word at a time. After that the request is compared again, so it finishes as a hit. A slot that is invalid or clean is refilled with no copy-back.

The split is set by parameters. The full-size configuration is a 13-bit tag, a 14-bit slot index and a 5-bit word offset within a 32-bit word address. The default parameters use a small slot and word field so that the storage stays small.

Top module: `dmc_cache_ctrl`

## Requirements
- R1: The word address splits, from most to least significant, into tag, slot index and word offset. With a 14-bit slot and a 5-bit word field, address 0xA035F014 gives tag 0x1406, slot 0x2F80 and word 0x14.
- R2: While reset is held, `cpu_ready` and `mem_req` are 0. Reset marks every slot invalid and clean, so the first access to any slot after reset refills it and writes nothing back.
- R3: A hit (slot valid and stored tag equal to the address tag) raises `cpu_ready` on the second clock edge after the edge that accepts the request. No memory request is made for a hit. `cpu_ready` is a one-cycle pulse.
- R4: A read returns, on `cpu_rdata` while `cpu_ready` is 1, the word that the word offset selects within the slot.
- R5: A write hit stores `cpu_wdata` in the selected word and marks the slot dirty. Later reads return the new value.
- R6: A miss on an invalid or clean slot performs exactly 2^WORD_W memory reads, at increasing word offsets starting from 0, with no memory writes. All of them use the request's tag and slot.
- R7: A miss on a valid dirty slot first writes all 2^WORD_W words back, at the address built from the stored tag and the slot, in increasing offset order. The refill reads start on the cycle after the last write-back word is accepted.
- R8: A write miss completes after the refill by merging the written word into the block. The slot is left dirty, so the next conflicting miss writes the block back.
- R9: A memory request (`mem_req`=1) keeps its address, direction and write data unchanged until `mem_ack` is seen at a clock edge. Each acknowledged cycle transfers one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory accepted the word this cycle |
| mem_rdata | input | DATA_W | Refill data, valid with `mem_ack` |

## Verification
A lost dirty bit shows up at the next conflicting miss of that slot: it has no write-back burst, and a later read of the evicted address returns stale memory data. A wrong valid bit or tag shows up on the very next access to that slot, as a memory burst where none was due or a missing one, and as the wrong hit latency. A refill counter or address mix-up shows up within one burst as out-of-order offsets, or as refill data in the wrong word, which the next read of that word exposes.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COMPARE   = 3'd1,
        ST_WRITEBACK = 3'd2,
        ST_REFILL    = 3'd3,
        ST_RESPOND   = 3'd4
    } dmc_state_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 14,
    parameter int WORD_W = 5
) (
    input  logic [ADDR_W-1:0]               addr,
    output logic [ADDR_W-SLOT_W-WORD_W-1:0] tag,
    output logic [SLOT_W-1:0]               slot,
    output logic [WORD_W-1:0]               word
);
    localparam int TAG_W = ADDR_W - SLOT_W - WORD_W;

    assign tag  = addr[ADDR_W-1 -: TAG_W];
    assign slot = addr[WORD_W +: SLOT_W];
    assign word = addr[WORD_W-1:0];

endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int TAG_W  = 26,
    parameter int SLOT_W = 4,
    parameter int WORD_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic [WORD_W-1:0] wb_word,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_load,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic              dirty_set
);
    localparam int SLOTS = 1 << SLOT_W;
    localparam int DEPTH = SLOTS << WORD_W;

    logic [SLOTS-1:0]  valid_q;
    logic [SLOTS-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [SLOTS];
    logic [DATA_W-1:0] data_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (tag_load) begin
                valid_q[slot] <= 1'b1;
                dirty_q[slot] <= 1'b0;
            end
            if (dirty_set) begin
                dirty_q[slot] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (tag_load) begin
            tag_q[slot] <= new_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[{slot, wr_word}] <= wr_data;
        end
    end

    assign line_valid = valid_q[slot];
    assign line_dirty = dirty_q[slot];
    assign line_tag   = tag_q[slot];
    assign rd_data    = data_q[{slot, rd_word}];
    assign wb_data    = data_q[{slot, wb_word}];

endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
    import dmc_pkg::*;
#(
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              req_we,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ack,
    output dmc_state_e        state,
    output logic [WORD_W-1:0] beat,
    output logic              accept,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              fill_wr,
    output logic              hit_wr,
    output logic              fill_done
);
    localparam logic [WORD_W-1:0] BEAT_LAST = '1;

    dmc_state_e state_q, state_d;
    logic [WORD_W-1:0] beat_q;
    logic beat_last;

    assign beat_last = (beat_q == BEAT_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (hit)               state_d = ST_RESPOND;
                else if (victim_dirty) state_d = ST_WRITEBACK;
                else                   state_d = ST_REFILL;
            end
            ST_WRITEBACK: begin
                if (mem_ack && beat_last) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (mem_ack && beat_last) state_d = ST_COMPARE;
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_wr   = 1'b0;
        hit_wr    = 1'b0;
        fill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = cpu_req;
            end
            ST_COMPARE: begin
                hit_wr = hit && req_we;
            end
            ST_WRITEBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                fill_wr   = mem_ack;
                fill_done = mem_ack && beat_last;
            end
            ST_RESPOND: begin
                cpu_ready = 1'b1;
            end
            default: begin
                cpu_ready = 1'b0;
            end
        endcase
    end

    // word counter for bursts; wraps to zero after the last word
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (mem_req && mem_ack) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign state = state_q;
    assign beat  = beat_q;

endmodule

// File: rtl/dmc_cache_ctrl.sv
module dmc_cache_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 4,
    parameter int WORD_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - SLOT_W - WORD_W;

    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [SLOT_W-1:0] req_slot;
    logic [WORD_W-1:0] req_word;

    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] rd_data, wb_data;

    dmc_state_e        state;
    logic [WORD_W-1:0] beat;
    logic              accept, fill_wr, hit_wr, fill_done;
    logic              hit, victim_dirty;

    logic              wr_en;
    logic [WORD_W-1:0] wr_word;
    logic [DATA_W-1:0] wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
        end else if (accept) begin
            req_addr_q  <= cpu_addr;
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
        end
    end

    dmc_addr_split #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .WORD_W (WORD_W)
    ) u_split (
        .addr (req_addr_q),
        .tag  (req_tag),
        .slot (req_slot),
        .word (req_word)
    );

    assign hit          = line_valid && (line_tag == req_tag);
    assign victim_dirty = line_valid && line_dirty;

    dmc_fsm #(
        .WORD_W (WORD_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .req_we       (req_we_q),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .beat         (beat),
        .accept       (accept),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_wr      (fill_wr),
        .hit_wr       (hit_wr),
        .fill_done    (fill_done)
    );

    // one write port: refill words or the merged write-hit word
    always_comb begin
        wr_en   = fill_wr || hit_wr;
        wr_word = fill_wr ? beat : req_word;
        wr_data = fill_wr ? mem_rdata : req_wdata_q;
    end

    dmc_store #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .WORD_W (WORD_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .slot       (req_slot),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .rd_word    (req_word),
        .rd_data    (rd_data),
        .wb_word    (beat),
        .wb_data    (wb_data),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .tag_load   (fill_done),
        .new_tag    (req_tag),
        .dirty_set  (hit_wr)
    );

    assign mem_addr  = (state == ST_WRITEBACK) ? {line_tag, req_slot, beat}
                                               : {req_tag,  req_slot, beat};
    assign mem_wdata = wb_data;
    assign cpu_rdata = rd_data;

endmodule

// File: rtl/dmc_cache_ctrl_chk.sv
module dmc_cache_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 4,
    parameter int WORD_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    localparam logic [WORD_W-1:0] OFF_LAST = '1;
    localparam logic [WORD_W-1:0] OFF_ONE  = 1;

    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_ready_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    assert_burst_order_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && (mem_addr[WORD_W-1:0] != OFF_LAST))
        |=> (mem_req && (mem_we == $past(mem_we))
             && (mem_addr[WORD_W-1:0] == ($past(mem_addr[WORD_W-1:0]) + OFF_ONE))));

    assert_mem_slot_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && cpu_req)
        |-> (mem_addr[WORD_W +: SLOT_W] == cpu_addr[WORD_W +: SLOT_W]));

    assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_we && (mem_addr[WORD_W-1:0] == OFF_LAST))
        |=> (mem_req && !mem_we && (mem_addr[WORD_W-1:0] == '0)));

    assert_fill_end_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we && (mem_addr[WORD_W-1:0] == OFF_LAST))
        |=> !mem_req);

endmodule

bind dmc_cache_ctrl dmc_cache_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .WORD_W (WORD_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/dmc_cache_ctrl_test.sv
module dmc_cache_ctrl_test;

    localparam int ADDR_W = 32;
    localparam int SLOT_W = 4;
    localparam int WORD_W = 2;
    localparam int DATA_W = 32;
    localparam int TAG_W  = ADDR_W - SLOT_W - WORD_W;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int BLOCK  = 1 << WORD_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    dmc_cache_ctrl #(
        .ADDR_W (ADDR_W), .SLOT_W (SLOT_W), .WORD_W (WORD_W), .DATA_W (DATA_W)
    ) uut (
        .clk (clk), .rst (rst),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
        .cpu_wdata (cpu_wdata), .cpu_ready (cpu_ready), .cpu_rdata (cpu_rdata),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
    );

    // full-size field split, checked for R1
    logic [31:0] big_addr = 32'hA035_F014;
    logic [12:0] big_tag;
    logic [13:0] big_slot;
    logic [4:0]  big_word;
    dmc_addr_split #(.ADDR_W (32), .SLOT_W (14), .WORD_W (5)) u_big (
        .addr (big_addr), .tag (big_tag), .slot (big_slot), .word (big_word)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- backing memory model ----------------
    logic [DATA_W-1:0] bmem [logic [ADDR_W-1:0]];
    logic [15:0] lfsr = 16'hACE1;
    bit stall_en = 1'b0;
    int rd_words = 0;
    int wr_words = 0;

    function automatic logic [DATA_W-1:0] seed_val(input logic [ADDR_W-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [DATA_W-1:0] mem_val(input logic [ADDR_W-1:0] a);
        if (bmem.exists(a)) return bmem[a];
        return seed_val(a);
    endfunction

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst && mem_req && (!stall_en || lfsr[0])) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                bmem[mem_addr] = mem_wdata;
                wr_words++;
            end else begin
                mem_rdata <= mem_val(mem_addr);
                rd_words++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ---------------- reference model and scoreboard ----------------
    logic [DATA_W-1:0] refm [logic [ADDR_W-1:0]];
    bit               m_valid [SLOTS];
    bit               m_dirty [SLOTS];
    logic [TAG_W-1:0] m_tag   [SLOTS];

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             rq;
    } sb_item_t;
    sb_item_t sbq [$];

    function automatic logic [DATA_W-1:0] ref_val(input logic [ADDR_W-1:0] a);
        if (refm.exists(a)) return refm[a];
        return seed_val(a);
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int sl, input int wd);
        return {TAG_W'(tg), SLOT_W'(sl), WORD_W'(wd)};
    endfunction

    // monitor: every ready pulse of a read pops one expected word
    bit pending_read = 1'b0;
    always @(negedge clk) begin
        if (cpu_ready && pending_read) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R4 scoreboard empty", 64'(cpu_rdata), 64'd0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(cpu_rdata == it.exp, it.rq, 64'(cpu_rdata), 64'(it.exp));
            end
        end
    end

    task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input string rq);
        int sl;
        logic [TAG_W-1:0] tg;
        bit hit;
        int exp_r, exp_w, lat;
        sl = int'(a[WORD_W +: SLOT_W]);
        tg = a[ADDR_W-1 -: TAG_W];
        hit = m_valid[sl] && (m_tag[sl] == tg);
        exp_w = (!hit && m_valid[sl] && m_dirty[sl]) ? BLOCK : 0;
        exp_r = hit ? 0 : BLOCK;
        if (!we) begin
            sb_item_t it;
            it.exp = ref_val(a);
            it.rq  = {rq, " read data"};
            sbq.push_back(it);
        end else begin
            refm[a] = d;
        end
        m_valid[sl] = 1'b1;
        m_tag[sl]   = tg;
        m_dirty[sl] = (hit && m_dirty[sl]) || we;

        @(negedge clk);
        rd_words = 0;
        wr_words = 0;
        pending_read = !we;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready);
        cpu_req = 1'b0;
        if (hit) check(lat == 2, {rq, " R3 hit latency"}, 64'(lat), 64'd2);
        check(rd_words == exp_r, {rq, " R6 refill words"}, 64'(rd_words), 64'(exp_r));
        check(wr_words == exp_w, {rq, " R7 write-back words"}, 64'(wr_words), 64'(exp_w));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b0, "R2 ready in reset", 64'(cpu_ready), 64'd0);
        check(mem_req == 1'b0, "R2 mem_req in reset", 64'(mem_req), 64'd0);
        rst = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            m_valid[s] = 1'b0;
            m_dirty[s] = 1'b0;
        end
    endtask

    // watchdog
    int wd_cycles = 0;
    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 100000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", wd_cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: full-size field split
        #1;
        check(big_tag == 13'h1406, "R1 tag", 64'(big_tag), 64'h1406);
        check(big_slot == 14'h2F80, "R1 slot", 64'(big_slot), 64'h2F80);
        check(big_word == 5'h14, "R1 word", 64'(big_word), 64'h14);

        // R2/R6: first access after reset refills, no write-back
        access(1'b0, mk(1, 3, 2), '0, "R2 cold miss");
        // R3/R4: hits on the refilled block
        access(1'b0, mk(1, 3, 0), '0, "R4 hit word0");
        access(1'b0, mk(1, 3, 3), '0, "R4 hit word3");
        // R5: write hit, read back
        access(1'b1, mk(1, 3, 1), 32'hDEAD_BEEF, "R5 write hit");
        access(1'b0, mk(1, 3, 1), '0, "R5 read after write");
        // R7: conflict on dirty slot writes back then refills
        access(1'b0, mk(2, 3, 0), '0, "R7 dirty conflict");
        check(mem_val(mk(1, 3, 1)) == 32'hDEAD_BEEF, "R7 written-back word",
              64'(mem_val(mk(1, 3, 1))), 64'hDEAD_BEEF);
        // R6: clean conflict, data comes back from memory
        access(1'b0, mk(1, 3, 1), '0, "R6 clean conflict");

        // R2: reset forgets the cached block
        do_reset();
        access(1'b0, mk(1, 3, 1), '0, "R2 miss after reset");

        // R8: write miss merges after refill and leaves slot dirty
        access(1'b1, mk(5, 7, 3), 32'h1234_5678, "R8 write miss");
        access(1'b0, mk(5, 7, 3), '0, "R8 read merged");
        access(1'b0, mk(5, 7, 0), '0, "R8 neighbour word");
        access(1'b0, mk(6, 7, 0), '0, "R8 dirty eviction");
        access(1'b0, mk(5, 7, 3), '0, "R8 reload merged");

        // R9: memory stalls, mixed traffic over a few slots
        stall_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            access((i % 3) == 0, mk((i * 7) % 3 + 1, (i * 5) % 4, i % 4),
                   32'(i) * 32'h0101_0101 ^ 32'hC3C3_0000, "R9 stalled");
        end
        stall_en = 1'b0;

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R4 scoreboard drained", 64'(sbq.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule